// File: doc/BRIEF.md
# Gated Timer With Polarity Select

This block is a 16-bit up-counter that advances by one on each count strobe. The count strobe is a single-cycle pulse in the system clock domain that stands in for the timer clock. The counter can run freely, or it can be qualified by a gate. The gate level is taken from one of four external sources: a dedicated gate pin, two comparator-style inputs and a partner-timer match pulse. A two-flop synchronizer carries the selected source into the clock domain. A polarity bit then decides whether a high or a low synchronized level lets the counter run.

Software-style access goes through an 8-bit gate-control register and a loadable count. The count and a one-cycle overflow pulse are always visible. The synchronized gate level, after polarity is applied, is also brought out so that the state of the gate can be seen.

Top module: `gated_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the count, the gate-control register and the overflow flag. It also clears the synchronizer flops.
- R2: With gate mode off (control bit 7 = 0), the count increases by one on every cycle in which `cntStrobe` is high.
- R3: With gate mode on and polarity 1 (control bit 6 = 1), a strobe increments the count only while the synchronized gate level is 1. The count holds while that level is 0.
- R4: With gate mode on and polarity 0, a strobe increments the count only while the synchronized gate level is 0. The count holds while that level is 1.
- R5: The gate-control register uses bit 7 for gate enable, bit 6 for polarity and bits 1:0 for source select. A write stores those fields only, and the read port returns 0 in bits 5:2.
- R6: The select value k (0 to 3) picks `gateSrc[k]` as the gate source. Index 0 is the gate pin, 1 and 2 are the comparator inputs, and 3 is the partner-match pulse.
- R7: The selected source passes through two flops. A level change applied before edge n appears on `gateVal` after edge n+1, and it first governs the strobe sampled at edge n+2.
- R8: `gateVal` equals the synchronized level when polarity is 1, and its inverse when polarity is 0.
- R9: When `cntWrEn` is high, the count takes `cntWrData` at the next edge, even if an increment is due in the same cycle.
- R10: An increment from 0xFFFF gives 0x0000 and raises `overflow` for exactly the following cycle.
- R11: In a cycle with no strobe and no load, the count is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cntStrobe | input | 1 | Count-edge strobe, one cycle per timer clock edge |
| cfgWrEn | input | 1 | Write strobe for the gate-control register |
| cfgWrData | input | 8 | Gate-control write data (bit 7 enable, bit 6 polarity, bits 1:0 select) |
| cfgRdData | output | 8 | Gate-control readback |
| gateSrc | input | 4 | Gate sources: 0 pin, 1–2 comparators, 3 partner match |
| gateVal | output | 1 | Synchronized gate level after polarity |
| cntWrEn | input | 1 | Count load strobe |
| cntWrData | input | 16 | Count load value |
| count | output | 16 | Current count |
| overflow | output | 1 | One-cycle pulse after wrap from 0xFFFF |

## Verification
The assertions assume that `cntStrobe` and `cntWrEn` are synchronous to `clk` and sampled once per edge. They make no assumption about the gate sources, which may change at any time because the synchronizer absorbs them. The random stimulus therefore drives the strobes and load on the falling edge. It flips each gate source with low probability, so that gated stretches of both polarities last long enough to be seen. The gate-control register is written rarely, so that each polarity and select setting lasts for many cycles. Directed cases cover the wrap at 0xFFFF, a load that collides with an increment, the reserved control bits and the two-edge synchronizer latency for each source.

// File: rtl/gt_pkg.sv
package gt_pkg;
  parameter int GT_SEL_W = 2;

  typedef struct packed {
    logic                gateEn;
    logic                gatePol;
    logic [GT_SEL_W-1:0] gateSel;
  } gate_cfg_t;

  typedef struct packed {
    logic load;
    logic inc;
  } cnt_ctrl_t;
endpackage

// File: rtl/gt_gate_ctrl.sv
module gt_gate_ctrl
  import gt_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cntStrobe,
  input  logic               cntWrEn,
  input  logic               cfgWrEn,
  input  logic [REG_W-1:0]   cfgWrData,
  output logic [REG_W-1:0]   cfgRdData,
  input  logic [NUM_SRC-1:0] gateSrc,
  output logic               gateVal,
  output cnt_ctrl_t          ctrl
);
  localparam int EN_BIT  = REG_W - 1;
  localparam int POL_BIT = REG_W - 2;

  gate_cfg_t cfgQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic selected;
  logic syncOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ <= '0;
    end else if (cfgWrEn) begin
      cfgQ.gateEn  <= cfgWrData[EN_BIT];
      cfgQ.gatePol <= cfgWrData[POL_BIT];
      cfgQ.gateSel <= cfgWrData[GT_SEL_W-1:0];
    end
  end

  always_comb begin
    cfgRdData                 = '0;
    cfgRdData[EN_BIT]         = cfgQ.gateEn;
    cfgRdData[POL_BIT]        = cfgQ.gatePol;
    cfgRdData[GT_SEL_W-1:0]   = cfgQ.gateSel;
  end

  assign selected = gateSrc[cfgQ.gateSel];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= selected;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], selected};
      end
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];
  assign gateVal = cfgQ.gatePol ? syncOut : ~syncOut;

  always_comb begin
    ctrl.load = cntWrEn;
    ctrl.inc  = cntStrobe && (!cfgQ.gateEn || gateVal);
  end

  // R3/R4: a closed gate never lets an increment through
  assert_gate_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (cfgQ.gateEn && !gateVal) |-> !ctrl.inc);
  // R2: with gating off every strobe increments
  assert_free_run_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfgQ.gateEn && cntStrobe) |-> ctrl.inc);
  // R8: polarity flip with stable synchronizer inverts gateVal
  assert_pol_inverts_R8: assert property (@(posedge clk) disable iff (rst)
    ($stable(syncOut) && $changed(cfgQ.gatePol)) |-> (gateVal != $past(gateVal)));
endmodule

// File: rtl/gt_count_path.sv
module gt_count_path
  import gt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_ctrl_t        ctrl,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= 1'b0;
      if (ctrl.load) begin
        count <= loadData;
      end else if (ctrl.inc) begin
        count    <= count + 1'b1;
        overflow <= (count == CNT_MAX);
      end
    end
  end

  // R9: load wins over increment
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl.load |=> (count == $past(loadData)));
  // R11: no strobe, no load -> hold
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.load && !ctrl.inc) |=> $stable(count));
  // R10: overflow only right after a wrap to zero
  assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (count == '0));
  assert_no_double_ovf_R10: assert property (@(posedge clk) disable iff (rst)
    overflow |=> !overflow);
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 4,
  parameter int REG_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cntStrobe,
  input  logic               cfgWrEn,
  input  logic [REG_W-1:0]   cfgWrData,
  output logic [REG_W-1:0]   cfgRdData,
  input  logic [NUM_SRC-1:0] gateSrc,
  output logic               gateVal,
  input  logic               cntWrEn,
  input  logic [CNT_W-1:0]   cntWrData,
  output logic [CNT_W-1:0]   count,
  output logic               overflow
);
  cnt_ctrl_t ctrl;

  gt_gate_ctrl #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rst(rst), .cntStrobe(cntStrobe), .cntWrEn(cntWrEn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .gateSrc(gateSrc), .gateVal(gateVal), .ctrl(ctrl)
  );

  gt_count_path #(.CNT_W(CNT_W)) u_path (
    .clk(clk), .rst(rst), .ctrl(ctrl), .loadData(cntWrData),
    .count(count), .overflow(overflow)
  );

  // R1: reset leaves the block cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !overflow && cfgRdData == '0));
endmodule

// File: tb/gated_timer_bench.sv
module gated_timer_bench;
  logic clk = 1'b0;
  logic rst, cntStrobe, cfgWrEn, cntWrEn;
  logic [7:0] cfgWrData, cfgRdData;
  logic [3:0] gateSrc;
  logic gateVal, overflow;
  logic [15:0] cntWrData, count;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] mCnt;
  logic mOvf, mEn, mPol;
  logic [1:0] mSel, mSync;

  always #5 clk = ~clk;

  gated_timer u_gated_timer (
    .clk(clk), .rst(rst), .cntStrobe(cntStrobe), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .gateSrc(gateSrc),
    .gateVal(gateVal), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .count(count), .overflow(overflow)
  );

  function automatic logic [7:0] expCfg();
    return {mEn, mPol, 4'b0000, mSel};
  endfunction

  function automatic logic expGate();
    return mPol ? mSync[1] : ~mSync[1];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, compare after posedge
  task automatic step(input logic r, input logic st, input logic cw, input logic [7:0] cd,
                      input logic lw, input logic [15:0] ld, input logic [3:0] src);
    string tag;
    logic allow;
    @(negedge clk);
    rst = r; cntStrobe = st; cfgWrEn = cw; cfgWrData = cd;
    cntWrEn = lw; cntWrData = ld; gateSrc = src;
    allow = !mEn || expGate();
    if (r) begin
      tag = "R1";
      mCnt = '0; mOvf = 1'b0; mEn = 1'b0; mPol = 1'b0; mSel = '0; mSync = '0;
    end else begin
      if (lw) tag = "R9";
      else if (!st) tag = "R11";
      else if (!mEn) tag = "R2";
      else if (mPol) tag = "R3";
      else tag = "R4";
      mOvf = 1'b0;
      if (lw) mCnt = ld;
      else if (st && allow) begin
        mOvf = (mCnt == 16'hFFFF);
        mCnt = mCnt + 16'd1;
      end
      mSync = {mSync[0], src[mSel]};
      if (cw) begin mEn = cd[7]; mPol = cd[6]; mSel = cd[1:0]; end
    end
    @(posedge clk); #1;
    check(tag, 32'(count), 32'(mCnt));
    check("R10", 32'(overflow), 32'(mOvf));
    check("R8", 32'(gateVal), 32'(expGate()));
    check("R5", 32'(cfgRdData), 32'(expCfg()));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] src;
    void'($urandom(32'd2024));
    rst = 1; cntStrobe = 0; cfgWrEn = 0; cfgWrData = 0; cntWrEn = 0; cntWrData = 0; gateSrc = 0;
    mCnt = 'x; mOvf = 0; mEn = 0; mPol = 0; mSel = 0; mSync = 0;

    // R1 reset state
    step(1, 1, 1, 8'hFF, 1, 16'hABCD, 4'hF);
    step(1, 0, 0, 0, 0, 0, 4'h0);
    check("R1", 32'({count, overflow, cfgRdData}), 32'h0);

    // R2 free run
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, 0, 4'hF);
    check("R2", 32'(count), 32'd5);

    // R5 reserved bits read zero
    step(0, 0, 1, 8'hFF, 0, 0, 4'h0);
    check("R5", 32'(cfgRdData), 32'hC3);

    // R6/R7 per source: en=1 pol=1, select k, raise only source k
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 1, 8'hC0 | 8'(k), 1, 16'h0100, 4'h0);
      step(0, 1, 0, 0, 0, 0, 4'h0);
      step(0, 1, 0, 0, 0, 0, 4'h0);
      check("R7", 32'(count), 32'h0100);
      step(0, 1, 0, 0, 0, 0, 4'(1 << k));       // edge n: first flop
      check("R7", 32'(gateVal), 32'd0);
      step(0, 1, 0, 0, 0, 0, 4'(1 << k));       // edge n+1: gateVal updates
      check("R7", 32'(gateVal), 32'd1);
      check("R7", 32'(count), 32'h0100);
      step(0, 1, 0, 0, 0, 0, 4'(1 << k));       // edge n+2: counts
      check("R6", 32'(count), 32'h0101);
      step(0, 1, 0, 0, 0, 0, 4'(~(1 << k)));    // others high: still counts
      check("R6", 32'(count), 32'h0102);
    end

    // R4 polarity 0: gate low counts
    step(0, 0, 1, 8'h80, 1, 16'h0010, 4'h0);
    step(0, 1, 0, 0, 0, 0, 4'h0);
    step(0, 1, 0, 0, 0, 0, 4'h0);
    check("R4", 32'(count), 32'h0012);

    // R10 wrap and R9 collision
    step(0, 0, 1, 8'h00, 1, 16'hFFFF, 4'h0);
    step(0, 1, 0, 0, 0, 0, 4'h0);
    check("R10", 32'({overflow, count}), 32'h10000);
    step(0, 1, 0, 0, 0, 0, 4'h0);
    check("R10", 32'({overflow, count}), 32'h00001);
    step(0, 1, 0, 0, 1, 16'h1234, 4'h0);
    check("R9", 32'(count), 32'h1234);
    step(0, 0, 0, 0, 0, 0, 4'h0);
    check("R11", 32'(count), 32'h1234);

    // random phase
    src = 4'h0;
    for (int i = 0; i < 4000; i++) begin
      logic r, st, cw, lw;
      for (int b = 0; b < 4; b++) if ($urandom_range(0, 9) == 0) src[b] = ~src[b];
      r  = ($urandom_range(0, 499) == 0);
      st = ($urandom_range(0, 9) < 7);
      cw = ($urandom_range(0, 39) == 0);
      lw = ($urandom_range(0, 59) == 0);
      step(r, st, cw, 8'($urandom), lw,
           ($urandom_range(0, 1) == 0) ? 16'hFFF0 + 16'($urandom_range(0, 15)) : 16'($urandom),
           src);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule